// File: doc/BRIEF.md
# Prioritised interrupt level encoder

This block gathers the interrupt requests of the peripherals on a small 16-bit processor board and presents the most urgent one to the CPU as a 3-bit priority level. Each source has a fixed level. The abort button is on 1, the DMA engine on 2, the SCSI controller on 3, the floppy controller on 4, the timer on 5 and the parallel port on 7. Level 6 is never used. Level 7 cannot be masked, and software uses it for watchdog expiry and bus trigger events.

When the CPU runs an interrupt-acknowledge cycle for a level, the block answers in one of three ways. It can request autovectoring. It can return an 8-bit vector supplied by the requesting device. If nothing is pending on that level, it returns a fixed spurious vector. A board strap decides whether the DMA level is answered with the vector captured from the DMA engine or with autovectoring. The abort input and the DMA request are latched and are cleared only by their own acknowledge. The other requests follow their input lines.

Top module: `irq_level_encoder`

## Requirements
- R1: During reset and afterwards until a request arrives, `ipl_o` is 0, `iack_done_o` and `avec_o` are 0, and `vec_o` is 8'h00.
- R2: `ipl_o` is a register that holds the highest pending level, or 0 when nothing is pending. A change on a level-sensitive request (SCSI on level 3, floppy on 4, timer on 5, port on 7) appears on `ipl_o` at the first clock edge after the change.
- R3: `ipl_o` never shows level 6. With every source except the port pending, it shows 5.
- R4: `abort_ni` is active low. It passes through a two-flop synchroniser. Its falling edge latches level 1, which appears on `ipl_o` at the third rising edge after the input falls. The latch holds even after `abort_ni` returns high, and it clears only when level 1 is acknowledged.
- R5: A rising edge on `dma_req_i` latches a level-2 request and captures `dma_vec_i` at that edge. The request shows on `ipl_o` at the same edge. It stays pending until level 2 is acknowledged, which clears it at the acceptance edge even if `dma_req_i` stays high.
- R6: An acknowledge is accepted at the first rising edge where `iack_i` is high and was low at the previous edge. `iack_lvl_i` is sampled at that edge. `iack_done_o` is high for exactly the following cycle, and holding `iack_i` high gives no second response.
- R7: Acknowledging a pending level 1, 3 or 4 answers with `avec_o`=1 and `vec_o`=8'h00.
- R8: Acknowledging a pending level 5 or 7 answers with `avec_o`=0 and `vec_o` equal to `pit_vec_i` as sampled at acceptance.
- R9: Acknowledging a pending level 2 answers with the captured DMA vector and `avec_o`=0 when `dma_vec_sel_i` is 1. It answers with `avec_o`=1 and `vec_o`=8'h00 when the strap is 0.
- R10: Acknowledging a level that has nothing pending, including 0 and 6, answers with `vec_o`=8'h18, `avec_o`=0 and `iack_done_o`=1.
- R11: While `iack_i` is high, `ipl_o` keeps its value. It resumes tracking at the first edge after `iack_i` falls.
- R12: A port request (level 7) outranks every other pending source, latched ones included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_ni | input | 1 | Abort push-button, active low, asynchronous |
| dma_req_i | input | 1 | DMA engine request, latched on its rising edge |
| dma_vec_i | input | 8 | Vector offered by the DMA engine |
| scsi_req_i | input | 1 | SCSI controller request, level-sensitive |
| fdc_req_i | input | 1 | Floppy controller request, level-sensitive |
| tmr_req_i | input | 1 | Timer request, level-sensitive |
| port_req_i | input | 1 | Parallel port request (non-maskable), level-sensitive |
| pit_vec_i | input | 8 | Vector offered by the timer/port device |
| dma_vec_sel_i | input | 1 | Strap: 1 selects a vectored DMA acknowledge, 0 selects autovector |
| iack_i | input | 1 | Interrupt-acknowledge request from the CPU |
| iack_lvl_i | input | 3 | Level being acknowledged |
| ipl_o | output | 3 | Encoded priority level to the CPU |
| avec_o | output | 1 | Autovector strobe |
| vec_o | output | 8 | Vector returned to the CPU |
| iack_done_o | output | 1 | Acknowledge complete pulse |

## Verification
Single requests are raised and dropped in turn, then stacked, to show that the encoder picks the numerically highest level and skips level 6. The port request is also raised on top of the latched sources. Acknowledges are run on every level in both strap positions. A DMA vector input that changes after the request separates a vector captured at the request edge from one sampled at the acknowledge. A DMA request held high after its acknowledge separates edge latching from level tracking. The abort input is released before its acknowledge to show that it stays latched. Acknowledges on empty levels and long `iack_i` pulses cover the spurious and single-response cases. A long random run of requests and acknowledges is then compared cycle by cycle against a behavioural model.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned NUM_LVL = 1 << LVL_W;

  localparam logic [LVL_W-1:0] LVL_ABORT = 3'd1;
  localparam logic [LVL_W-1:0] LVL_DMA   = 3'd2;
  localparam logic [LVL_W-1:0] LVL_SCSI  = 3'd3;
  localparam logic [LVL_W-1:0] LVL_FDC   = 3'd4;
  localparam logic [LVL_W-1:0] LVL_TMR   = 3'd5;
  localparam logic [LVL_W-1:0] LVL_PORT  = 3'd7;

  typedef enum logic [1:0] {
    ACK_SPUR = 2'd0,
    ACK_AUTO = 2'd1,
    ACK_DMA  = 2'd2,
    ACK_PIT  = 2'd3
  } ack_mode_e;

  // Response style per level, before the pending check
  function automatic ack_mode_e lvl_mode(input logic [LVL_W-1:0] lvl, input logic dma_vec_sel);
    ack_mode_e m;
    unique case (lvl)
      LVL_ABORT, LVL_SCSI, LVL_FDC: m = ACK_AUTO;
      LVL_DMA:                      m = dma_vec_sel ? ACK_DMA : ACK_AUTO;
      LVL_TMR, LVL_PORT:            m = ACK_PIT;
      default:                      m = ACK_SPUR;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/irq_abort_sync.sv
module irq_abort_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_ni,
  input  logic clr_i,
  output logic pend_o
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;
  logic              pend_q;
  logic              fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], abort_ni};
      hist_q <= sync_q[STAGES-1];
    end
  end

  assign fall = hist_q & ~sync_q[STAGES-1];

  // new edge wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= fall | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q | fall;
endmodule

// File: rtl/irq_dma_latch.sv
module irq_dma_latch #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             clr_i,
  output logic             pend_o,
  output logic [VEC_W-1:0] vec_o
);
  logic             req_q;
  logic             pend_q;
  logic [VEC_W-1:0] vec_q;
  logic             rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= rise | (pend_q & ~clr_i);
      if (rise) vec_q <= vec_i;
    end
  end

  assign pend_o = pend_q | rise;
  assign vec_o  = rise ? vec_i : vec_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_enc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] pend_i,
  input  logic               hold_i,
  output logic [LVL_W-1:0]   lvl_o
);
  logic [LVL_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (pend_i[i]) nxt = LVL_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_o <= '0;
    else if (!hold_i) lvl_o <= nxt;
  end
endmodule

// File: rtl/irq_ack_resp.sv
module irq_ack_resp
  import irq_enc_pkg::*;
#(
  parameter int unsigned    VEC_W    = 8,
  parameter logic [VEC_W-1:0] SPUR_VEC = 8'h18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               iack_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic [NUM_LVL-1:0] pend_i,
  input  logic               dma_vec_sel_i,
  input  logic [VEC_W-1:0]   dma_vec_i,
  input  logic [VEC_W-1:0]   pit_vec_i,
  output logic               accept_o,
  output logic               done_o,
  output logic               avec_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic             busy_q;
  ack_mode_e        mode;
  logic             nxt_avec;
  logic [VEC_W-1:0] nxt_vec;

  assign accept_o = iack_i & ~busy_q;
  assign mode     = pend_i[lvl_i] ? lvl_mode(lvl_i, dma_vec_sel_i) : ACK_SPUR;

  always_comb begin
    nxt_avec = 1'b0;
    nxt_vec  = '0;
    unique case (mode)
      ACK_AUTO: nxt_avec = 1'b1;
      ACK_DMA:  nxt_vec  = dma_vec_i;
      ACK_PIT:  nxt_vec  = pit_vec_i;
      default:  nxt_vec  = SPUR_VEC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_o <= 1'b0;
      avec_o <= 1'b0;
      vec_o  <= '0;
    end else begin
      busy_q <= iack_i;
      done_o <= accept_o;
      avec_o <= accept_o & nxt_avec;
      vec_o  <= accept_o ? nxt_vec : '0;
    end
  end
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
  import irq_enc_pkg::*;
#(
  parameter int unsigned      VEC_W       = 8,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0] SPUR_VEC    = 8'h18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_ni,
  input  logic             dma_req_i,
  input  logic [VEC_W-1:0] dma_vec_i,
  input  logic             scsi_req_i,
  input  logic             fdc_req_i,
  input  logic             tmr_req_i,
  input  logic             port_req_i,
  input  logic [VEC_W-1:0] pit_vec_i,
  input  logic             dma_vec_sel_i,
  input  logic             iack_i,
  input  logic [2:0]       iack_lvl_i,
  output logic [2:0]       ipl_o,
  output logic             avec_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             iack_done_o
);
  logic               accept;
  logic               abort_pend, dma_pend;
  logic [VEC_W-1:0]   dma_vec;
  logic [NUM_LVL-1:0] pend;

  irq_abort_sync #(.STAGES(SYNC_STAGES)) u_abort (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .abort_ni (abort_ni),
    .clr_i    (accept && iack_lvl_i == LVL_ABORT),
    .pend_o   (abort_pend)
  );

  irq_dma_latch #(.VEC_W(VEC_W)) u_dma (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (dma_req_i),
    .vec_i  (dma_vec_i),
    .clr_i  (accept && iack_lvl_i == LVL_DMA),
    .pend_o (dma_pend),
    .vec_o  (dma_vec)
  );

  always_comb begin
    pend            = '0;
    pend[LVL_ABORT] = abort_pend;
    pend[LVL_DMA]   = dma_pend;
    pend[LVL_SCSI]  = scsi_req_i;
    pend[LVL_FDC]   = fdc_req_i;
    pend[LVL_TMR]   = tmr_req_i;
    pend[LVL_PORT]  = port_req_i;
  end

  irq_prio_enc u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .hold_i (iack_i),
    .lvl_o  (ipl_o)
  );

  irq_ack_resp #(.VEC_W(VEC_W), .SPUR_VEC(SPUR_VEC)) u_ack (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .iack_i        (iack_i),
    .lvl_i         (iack_lvl_i),
    .pend_i        (pend),
    .dma_vec_sel_i (dma_vec_sel_i),
    .dma_vec_i     (dma_vec),
    .pit_vec_i     (pit_vec_i),
    .accept_o      (accept),
    .done_o        (iack_done_o),
    .avec_o        (avec_o),
    .vec_o         (vec_o)
  );
endmodule

// File: rtl/irq_level_encoder_chk.sv
module irq_level_encoder_chk #(
  parameter int unsigned      VEC_W    = 8,
  parameter logic [VEC_W-1:0] SPUR_VEC = 8'h18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iack_i,
  input logic [2:0]       iack_lvl_i,
  input logic             port_req_i,
  input logic [2:0]       ipl_o,
  input logic             avec_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             iack_done_o
);
  p_no_lvl6_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipl_o != 3'd6);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_done_o |=> !iack_done_o);

  p_done_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_done_o |-> $past(iack_i));

  p_auto_novec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avec_o |-> (iack_done_o && vec_o == '0));

  p_spur_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_done_o && ($past(iack_lvl_i) == 3'd6 || $past(iack_lvl_i) == 3'd0))
      |-> (vec_o == SPUR_VEC && !avec_o));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(iack_i) |-> $stable(ipl_o));

  p_nmi_top_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_req_i && !iack_i) |=> ipl_o == 3'd7);
endmodule

bind irq_level_encoder irq_level_encoder_chk #(.VEC_W(VEC_W), .SPUR_VEC(SPUR_VEC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iack_i      (iack_i),
  .iack_lvl_i  (iack_lvl_i),
  .port_req_i  (port_req_i),
  .ipl_o       (ipl_o),
  .avec_o      (avec_o),
  .vec_o       (vec_o),
  .iack_done_o (iack_done_o)
);

// File: tb/irq_level_encoder_tb.sv
`timescale 1ns/1ps
module irq_level_encoder_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       abort_ni = 1'b1, dma_req = 1'b0, scsi = 1'b0, fdc = 1'b0, tmr = 1'b0, port = 1'b0;
  logic [7:0] dma_vec = 8'h00, pit_vec = 8'h00;
  logic       strap = 1'b0, iack = 1'b0;
  logic [2:0] iack_lvl = 3'd0;
  logic [2:0] ipl;
  logic       avec, done;
  logic [7:0] vec;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_level_encoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .abort_ni(abort_ni), .dma_req_i(dma_req), .dma_vec_i(dma_vec),
    .scsi_req_i(scsi), .fdc_req_i(fdc), .tmr_req_i(tmr), .port_req_i(port), .pit_vec_i(pit_vec),
    .dma_vec_sel_i(strap), .iack_i(iack), .iack_lvl_i(iack_lvl),
    .ipl_o(ipl), .avec_o(avec), .vec_o(vec), .iack_done_o(done)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit   abq[$];
  bit   m_ab, m_dma, m_dreq, m_busy, m_done, m_avec;
  int   m_dvec, m_vec, m_ipl;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      abq = '{1'b1, 1'b1, 1'b1};
      m_ab = 0; m_dma = 0; m_dreq = 0; m_busy = 0; m_done = 0; m_avec = 0;
      m_dvec = 0; m_vec = 0; m_ipl = 0;
    end else begin
      bit fall, aeff, rise, deff, acc, pnd;
      int dv, hi;
      fall = abq[2] && !abq[1];
      aeff = m_ab || fall;
      rise = dma_req && !m_dreq;
      deff = m_dma || rise;
      dv   = rise ? int'(dma_vec) : m_dvec;
      hi = 0;
      if (aeff) hi = 1;
      if (deff) hi = 2;
      if (scsi) hi = 3;
      if (fdc)  hi = 4;
      if (tmr)  hi = 5;
      if (port) hi = 7;
      acc = iack && !m_busy;
      m_done = acc; m_avec = 0; m_vec = 0;
      if (acc) begin
        case (iack_lvl)
          3'd1: pnd = aeff;
          3'd2: pnd = deff;
          3'd3: pnd = scsi;
          3'd4: pnd = fdc;
          3'd5: pnd = tmr;
          3'd7: pnd = port;
          default: pnd = 0;
        endcase
        if (!pnd) m_vec = 'h18;
        else if (iack_lvl == 3'd5 || iack_lvl == 3'd7) m_vec = int'(pit_vec);
        else if (iack_lvl == 3'd2 && strap) m_vec = dv;
        else m_avec = 1;
      end
      m_ab   = fall || (m_ab && !(acc && iack_lvl == 3'd1));
      m_dma  = rise || (m_dma && !(acc && iack_lvl == 3'd2));
      m_dvec = dv;
      m_dreq = dma_req;
      m_busy = iack;
      if (!iack) m_ipl = hi;
      abq.push_front(abort_ni);
      void'(abq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R2 ipl", int'(ipl), m_ipl);
      chk("R6 done", int'(done), int'(m_done));
      chk("R7 avec", int'(avec), int'(m_avec));
      chk("R8 vec", int'(vec), m_vec);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  logic       r_done, r_avec;
  logic [7:0] r_vec;
  task automatic ack(logic [2:0] lvl, int hold);
    iack = 1'b1; iack_lvl = lvl;
    step(1);
    r_done = done; r_avec = avec; r_vec = vec;
    for (int i = 1; i < hold; i++) begin
      step(1);
      chk("R6 single response", int'(done), 0);
    end
    iack = 1'b0;
    step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1);
    chk("R1 ipl in reset", int'(ipl), 0);
    step(2);
    rst_ni = 1'b1;
    step(1);
    chk("R1 ipl", int'(ipl), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 avec", int'(avec), 0);
    chk("R1 vec", int'(vec), 0);

    // R2 priority among level-sensitive sources
    scsi = 1; step(1); chk("R2 scsi", int'(ipl), 3);
    fdc = 1;  step(1); chk("R2 fdc over scsi", int'(ipl), 4);
    scsi = 0; step(1); chk("R2 fdc alone", int'(ipl), 4);
    fdc = 0;  step(1); chk("R2 none", int'(ipl), 0);
    tmr = 1; scsi = 1; step(1); chk("R2 tmr over scsi", int'(ipl), 5);
    port = 1; step(1); chk("R12 port top", int'(ipl), 7);
    tmr = 0; scsi = 0; port = 0; step(1);

    // R7 autovector on level 3, R6 long iack gives one response
    scsi = 1; step(1);
    ack(3'd3, 3);
    chk("R6 done", int'(r_done), 1);
    chk("R7 avec", int'(r_avec), 1);
    chk("R7 vec", int'(r_vec), 0);
    scsi = 0; step(1);

    // R8 device vectors
    tmr = 1; pit_vec = 8'h45; step(1);
    ack(3'd5, 1);
    chk("R8 tmr avec", int'(r_avec), 0);
    chk("R8 tmr vec", int'(r_vec), 'h45);
    tmr = 0; port = 1; pit_vec = 8'h77; step(1);
    ack(3'd7, 1);
    chk("R8 port vec", int'(r_vec), 'h77);
    port = 0; step(1);

    // R5/R9 DMA with strap removed
    strap = 0; dma_vec = 8'hA5; dma_req = 1; step(1);
    chk("R5 dma latched", int'(ipl), 2);
    dma_vec = 8'h00; step(2);
    chk("R5 dma held", int'(ipl), 2);
    ack(3'd2, 1);
    chk("R9 strap0 avec", int'(r_avec), 1);
    chk("R9 strap0 vec", int'(r_vec), 0);
    chk("R5 cleared by ack", int'(ipl), 0);
    step(2);
    chk("R5 held request not relatched", int'(ipl), 0);

    // R9 strap fitted: captured vector
    dma_req = 0; step(1);
    strap = 1; dma_vec = 8'h3C; dma_req = 1; step(1);
    dma_vec = 8'hC3; step(1);
    ack(3'd2, 1);
    chk("R9 strap1 avec", int'(r_avec), 0);
    chk("R9 strap1 vec", int'(r_vec), 'h3C);
    dma_req = 0; step(1);

    // R4 abort synchroniser and latch
    abort_ni = 0; step(2);
    chk("R4 abort not yet", int'(ipl), 0);
    step(1);
    chk("R4 abort level", int'(ipl), 1);
    abort_ni = 1; step(4);
    chk("R4 abort latched", int'(ipl), 1);
    ack(3'd1, 1);
    chk("R4 abort avec", int'(r_avec), 1);
    chk("R4 abort cleared", int'(ipl), 0);

    // R10 spurious
    ack(3'd6, 1);
    chk("R10 lvl6 done", int'(r_done), 1);
    chk("R10 lvl6 vec", int'(r_vec), 'h18);
    chk("R10 lvl6 avec", int'(r_avec), 0);
    ack(3'd4, 1);
    chk("R10 empty lvl4 vec", int'(r_vec), 'h18);
    ack(3'd0, 1);
    chk("R10 lvl0 vec", int'(r_vec), 'h18);

    // R3 level 6 skipped
    scsi = 1; fdc = 1; tmr = 1; step(1);
    chk("R3 no level 6", int'(ipl), 5);
    fdc = 0; tmr = 0; step(1);

    // R11 hold during acknowledge
    chk("R11 pre", int'(ipl), 3);
    iack = 1; iack_lvl = 3'd3; port = 1; step(1);
    chk("R11 held", int'(ipl), 3);
    step(1);
    chk("R11 still held", int'(ipl), 3);
    iack = 0; step(1);
    chk("R11 resumes", int'(ipl), 7);
    port = 0; scsi = 0; step(2);

    // Random run against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) scsi = ~scsi;
      if ($urandom_range(0, 9) == 0) fdc = ~fdc;
      if ($urandom_range(0, 11) == 0) tmr = ~tmr;
      if ($urandom_range(0, 19) == 0) port = ~port;
      if ($urandom_range(0, 7) == 0) dma_req = ~dma_req;
      if ($urandom_range(0, 15) == 0) abort_ni = ~abort_ni;
      if ($urandom_range(0, 29) == 0) strap = ~strap;
      dma_vec = 8'($urandom);
      pit_vec = 8'($urandom);
      if (iack) begin
        if ($urandom_range(0, 1) == 0) iack = 0;
      end else if ($urandom_range(0, 5) == 0) begin
        iack = 1;
        iack_lvl = 3'($urandom_range(0, 7));
      end
    end
    iack = 0;
    step(3);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule